// File: doc/BRIEF.md
# Dual Address Cycle Generator

This block is the address-phase sequencer of a bus master. It accepts a 64-bit memory address with a four-bit bus command. It puts out one address phase when the upper 32 address bits are zero. It puts out a two-phase dual-address sequence when the address lies at or above 4 GB. After the last address phase the block hands the bus to one data-phase clock and then releases the frame signal.

A parameter selects a 32-bit or a 64-bit bus. On the wide bus, the first phase of a dual sequence also carries the upper address half and the real command on the upper lanes. A wide target can therefore finish decoding one clock earlier.

A target-side decoder is built into the block so that the lanes can be checked. It watches the frame, address/data and command/byte-enable lanes that the sequencer drives and rebuilds the full address and the command. Requests for a non-memory command with a non-zero upper half are refused, and so are requests that carry the dual-address code as their command. A refused request raises an error pulse and starts no bus cycle.

Top module: `dac_addr_seq`

## Requirements
- R1: After a synchronous active-high reset, the outputs are as follows: `frame_n` = 1, `req_ready` = 1, `req_err` = 0, `addr_phase` = 0, `data_go` = 0, `ad` all zero, `cbe_n` all ones, `dec_valid` = 0.
- R2: An accepted request whose address bits [63:32] are zero produces exactly one address phase in the clock after acceptance. That phase carries address bits [31:0] on `ad[31:0]` and the command on `cbe_n[3:0]`. On a wide bus the upper lanes show `ad[63:32]` = 0 and `cbe_n[7:4]` = 4'b1111.
- R3: An accepted memory request with non-zero address bits [63:32] starts with a first address phase that carries 4'b1101 on `cbe_n[3:0]` and address bits [31:0] on `ad[31:0]`. On a wide bus it also carries address bits [63:32] on `ad[63:32]` and the real command on `cbe_n[7:4]`.
- R4: The dual-address code is present for exactly one clock. The next clock is the second address phase, with address bits [63:32] on `ad[31:0]`, the real command on `cbe_n[3:0]`, and on a wide bus `ad[63:32]` = 0 and `cbe_n[7:4]` = 4'b1111.
- R5: `frame_n` goes low with the first address phase and stays low through the single data-phase clock that follows the last address phase. In that data-phase clock `data_go` = 1, `ad` = 0 and `cbe_n` = 0. `frame_n` returns high in the next clock.
- R6: The memory commands are 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111. A request is refused in two cases: its command is not one of these and address bits [63:32] are non-zero, or its command is 4'b1101. A refused request sets `req_err` for one clock and leaves `frame_n` high. A non-memory command with zero upper bits runs as in R2.
- R7: `req_ready` is 1 only while no sequence is in progress. A `req_valid` raised while `req_ready` is 0 has no effect on the outputs.
- R8: The decoder raises `dec_valid` for one clock, in the clock after the phase that completes its decode, with the full 64-bit address on `dec_addr` and the command on `dec_cmd`. A wide decoder completes a dual sequence from its first phase and sets `dec_early`. A narrow decoder waits for the second phase and leaves `dec_early` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | 64-bit target address |
| req_cmd | input | 4 | Bus command |
| req_ready | output | 1 | Sequencer idle, request taken this clock |
| req_err | output | 1 | One-clock refusal pulse |
| frame_n | output | 1 | Active-low frame |
| ad | output | BUS_W | Address/data lanes |
| cbe_n | output | BE_W | Command/byte-enable lanes |
| addr_phase | output | 1 | Lanes carry an address phase |
| data_go | output | 1 | Data-phase hand-off clock |
| dec_valid | output | 1 | Decoder result valid |
| dec_addr | output | ADDR_W | Decoded address |
| dec_cmd | output | 4 | Decoded command |
| dec_early | output | 1 | Decode finished in the first phase |

## Verification
The assertions rely on two things. The decoder's frame and lanes come only from this sequencer. Requests arrive either while the block is idle or as stray pulses while it is busy. Under those conditions a falling frame always opens a fresh sequence, and the dual-address code can never be followed by itself.

The stimulus respects this. Each request is held for one clock, and only once `req_ready` is seen high. Single one-clock pokes with unrelated values are added in the middle of a sequence. Addresses cover values just below and exactly at 4 GB, full-width patterns, refused commands, and a swept set of computed address and command pairs.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam logic [3:0] CMD_DUAL = 4'b1101;

  typedef enum logic [1:0] {PH_IDLE, PH_ADR1, PH_ADR2, PH_DATA} phase_e;
  typedef enum logic [2:0] {LN_IDLE, LN_SINGLE, LN_DUAL1, LN_DUAL2, LN_DATA} lane_e;

  function automatic logic is_mem_cmd(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
           (c == 4'b1110) || (c == 4'b1111);
  endfunction
endpackage

// File: rtl/dac_req_check.sv
module dac_req_check #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0] hi,
  input  logic [3:0]        cmd,
  output logic              reject,
  output logic              dual
);
  import dac_pkg::*;
  logic hi_nz;
  logic mem;
  assign hi_nz  = |hi;
  assign mem    = is_mem_cmd(cmd);
  assign reject = (cmd == CMD_DUAL) || (!mem && hi_nz);
  assign dual   = hi_nz && mem;
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl #(
  parameter int WIDE   = 1,
  parameter int HALF_W = 32,
  parameter int BUS_W  = 64,
  parameter int BE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [HALF_W-1:0] req_lo,
  input  logic [HALF_W-1:0] req_hi,
  input  logic [3:0]        req_cmd,
  input  logic              reject,
  input  logic              dual,
  output logic              ready,
  output logic              err,
  output logic              frame_n,
  output logic [BUS_W-1:0]  ad,
  output logic [BE_W-1:0]   cbe_n,
  output logic              addr_phase,
  output logic              data_go
);
  import dac_pkg::*;

  phase_e            ph, nxt_ph;
  lane_e             lane;
  logic              dual_q;
  logic [HALF_W-1:0] hi_q;
  logic [3:0]        cmd_q;
  logic              take;
  logic [HALF_W-1:0] lo_ad;
  logic [3:0]        lo_cbe;
  logic [BUS_W-1:0]  nxt_ad;
  logic [BE_W-1:0]   nxt_cbe;

  assign ready = (ph == PH_IDLE);
  assign take  = ready && req_valid && !reject;

  always_comb begin
    nxt_ph = ph;
    lane   = LN_IDLE;
    case (ph)
      PH_IDLE: if (take) begin
        nxt_ph = PH_ADR1;
        lane   = dual ? LN_DUAL1 : LN_SINGLE;
      end
      PH_ADR1: begin
        nxt_ph = dual_q ? PH_ADR2 : PH_DATA;
        lane   = dual_q ? LN_DUAL2 : LN_DATA;
      end
      PH_ADR2: begin
        nxt_ph = PH_DATA;
        lane   = LN_DATA;
      end
      default: begin
        nxt_ph = PH_IDLE;
        lane   = LN_IDLE;
      end
    endcase
  end

  always_comb begin
    case (lane)
      LN_SINGLE: begin lo_ad = req_lo;          lo_cbe = req_cmd;  end
      LN_DUAL1:  begin lo_ad = req_lo;          lo_cbe = CMD_DUAL; end
      LN_DUAL2:  begin lo_ad = hi_q;            lo_cbe = cmd_q;    end
      LN_DATA:   begin lo_ad = '0;              lo_cbe = 4'b0000;  end
      default:   begin lo_ad = '0;              lo_cbe = 4'b1111;  end
    endcase
  end

  generate
    if (WIDE != 0) begin : g_wide
      logic [HALF_W-1:0] up_ad;
      logic [3:0]        up_cbe;
      always_comb begin
        case (lane)
          LN_DUAL1: begin up_ad = req_hi; up_cbe = req_cmd; end
          LN_DATA:  begin up_ad = '0;     up_cbe = 4'b0000; end
          default:  begin up_ad = '0;     up_cbe = 4'b1111; end
        endcase
      end
      assign nxt_ad  = {up_ad, lo_ad};
      assign nxt_cbe = {up_cbe, lo_cbe};
    end else begin : g_narrow
      assign nxt_ad  = lo_ad;
      assign nxt_cbe = lo_cbe;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      dual_q     <= 1'b0;
      hi_q       <= '0;
      cmd_q      <= '0;
      err        <= 1'b0;
      frame_n    <= 1'b1;
      ad         <= '0;
      cbe_n      <= '1;
      addr_phase <= 1'b0;
      data_go    <= 1'b0;
    end else begin
      ph         <= nxt_ph;
      err        <= ready && req_valid && reject;
      ad         <= nxt_ad;
      cbe_n      <= nxt_cbe;
      addr_phase <= (lane == LN_SINGLE) || (lane == LN_DUAL1) || (lane == LN_DUAL2);
      data_go    <= (lane == LN_DATA);
      frame_n    <= (nxt_ph == PH_IDLE);
      if (take) begin
        dual_q <= dual;
        hi_q   <= req_hi;
        cmd_q  <= req_cmd;
      end
    end
  end

  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    err |-> frame_n);  // R6
  AST_DUAL_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    (!frame_n && cbe_n[3:0] == CMD_DUAL) |=> (cbe_n[3:0] != CMD_DUAL));  // R4
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n) |=> !frame_n);  // R5
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    data_go |-> $past(addr_phase));  // R5
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    ready |-> frame_n);  // R7
  AST_LOW_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && req_hi == '0) |=> (cbe_n[3:0] != CMD_DUAL));  // R2
endmodule

// File: rtl/dac_tgt_decode.sv
module dac_tgt_decode #(
  parameter int WIDE   = 1,
  parameter int HALF_W = 32,
  parameter int BUS_W  = 64,
  parameter int BE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_n,
  input  logic [BUS_W-1:0]    ad,
  input  logic [BE_W-1:0]     cbe_n,
  output logic                dec_valid,
  output logic [2*HALF_W-1:0] dec_addr,
  output logic [3:0]          dec_cmd,
  output logic                dec_early
);
  import dac_pkg::*;

  logic frame_q;
  logic start;
  assign start = !frame_n && frame_q;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b1;
    else     frame_q <= frame_n;
  end

  generate
    if (WIDE != 0) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst) begin
          dec_valid <= 1'b0;
          dec_addr  <= '0;
          dec_cmd   <= '0;
          dec_early <= 1'b0;
        end else begin
          dec_valid <= start;
          dec_early <= 1'b0;
          if (start) begin
            if (cbe_n[3:0] == CMD_DUAL) begin
              dec_addr  <= ad;
              dec_cmd   <= cbe_n[BE_W-1 -: 4];
              dec_early <= 1'b1;
            end else begin
              dec_addr <= {{HALF_W{1'b0}}, ad[HALF_W-1:0]};
              dec_cmd  <= cbe_n[3:0];
            end
          end
        end
      end
    end else begin : g_narrow
      logic              wait2;
      logic [HALF_W-1:0] lo_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dec_valid <= 1'b0;
          dec_addr  <= '0;
          dec_cmd   <= '0;
          dec_early <= 1'b0;
          wait2     <= 1'b0;
          lo_q      <= '0;
        end else begin
          dec_valid <= 1'b0;
          dec_early <= 1'b0;
          wait2     <= 1'b0;
          if (wait2) begin
            dec_valid <= 1'b1;
            dec_addr  <= {ad, lo_q};
            dec_cmd   <= cbe_n;
          end else if (start) begin
            if (cbe_n == CMD_DUAL) begin
              lo_q  <= ad;
              wait2 <= 1'b1;
            end else begin
              dec_valid <= 1'b1;
              dec_addr  <= {{HALF_W{1'b0}}, ad};
              dec_cmd   <= cbe_n;
            end
          end
        end
      end
    end
  endgenerate

  AST_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
    dec_early |-> dec_valid);  // R8
  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);  // R8
endmodule

// File: rtl/dac_addr_seq.sv
module dac_addr_seq #(
  parameter int WIDE   = 1,
  parameter int ADDR_W = 64,
  localparam int HALF_W = ADDR_W / 2,
  localparam int BUS_W  = (WIDE != 0) ? ADDR_W : HALF_W,
  localparam int BE_W   = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_cmd,
  output logic              req_ready,
  output logic              req_err,
  output logic              frame_n,
  output logic [BUS_W-1:0]  ad,
  output logic [BE_W-1:0]   cbe_n,
  output logic              addr_phase,
  output logic              data_go,
  output logic              dec_valid,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [3:0]        dec_cmd,
  output logic              dec_early
);
  logic reject;
  logic dual;

  dac_req_check #(.HALF_W(HALF_W)) u_check (
    .hi     (req_addr[ADDR_W-1:HALF_W]),
    .cmd    (req_cmd),
    .reject (reject),
    .dual   (dual)
  );

  dac_seq_ctrl #(.WIDE(WIDE), .HALF_W(HALF_W), .BUS_W(BUS_W), .BE_W(BE_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_lo     (req_addr[HALF_W-1:0]),
    .req_hi     (req_addr[ADDR_W-1:HALF_W]),
    .req_cmd    (req_cmd),
    .reject     (reject),
    .dual       (dual),
    .ready      (req_ready),
    .err        (req_err),
    .frame_n    (frame_n),
    .ad         (ad),
    .cbe_n      (cbe_n),
    .addr_phase (addr_phase),
    .data_go    (data_go)
  );

  dac_tgt_decode #(.WIDE(WIDE), .HALF_W(HALF_W), .BUS_W(BUS_W), .BE_W(BE_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .ad        (ad),
    .cbe_n     (cbe_n),
    .dec_valid (dec_valid),
    .dec_addr  (dec_addr),
    .dec_cmd   (dec_cmd),
    .dec_early (dec_early)
  );
endmodule

// File: tb/sim_dac_addr_seq.sv
`timescale 1ns/1ps
module sim_dac_addr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;

  logic        w_ready, w_err, w_frame, w_aph, w_dgo, w_dv, w_early;
  logic [63:0] w_ad, w_daddr;
  logic [7:0]  w_cbe;
  logic [3:0]  w_dcmd;
  logic        n_ready, n_err, n_frame, n_aph, n_dgo, n_dv, n_early;
  logic [31:0] n_ad;
  logic [63:0] n_daddr;
  logic [3:0]  n_cbe, n_dcmd;

  int runs = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_addr_seq #(.WIDE(1)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
    .req_ready(w_ready), .req_err(w_err), .frame_n(w_frame), .ad(w_ad), .cbe_n(w_cbe),
    .addr_phase(w_aph), .data_go(w_dgo), .dec_valid(w_dv), .dec_addr(w_daddr),
    .dec_cmd(w_dcmd), .dec_early(w_early));

  dac_addr_seq #(.WIDE(0)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
    .req_ready(n_ready), .req_err(n_err), .frame_n(n_frame), .ad(n_ad), .cbe_n(n_cbe),
    .addr_phase(n_aph), .data_go(n_dgo), .dec_valid(n_dv), .dec_addr(n_daddr),
    .dec_cmd(n_dcmd), .dec_early(n_early));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference model: step 0 idle, 1 first address, 2 second address, 3 data
  int          step = 0;
  bit          m_dual, m_err;
  logic [63:0] m_addr;
  logic [3:0]  m_cmd;
  bit          e_dvw, e_dvn, e_early;
  logic [63:0] e_daddr;
  logic [3:0]  e_dcmd;

  function automatic bit mem_cmd(input logic [3:0] c);
    return c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      step = 0; m_err = 0; e_dvw = 0; e_dvn = 0; e_early = 0;
    end else begin
      e_dvw = (step == 1);
      e_dvn = (step == 1 && !m_dual) || (step == 2);
      e_early = (step == 1) && m_dual;
      e_daddr = m_addr;
      e_dcmd = m_cmd;
      m_err = 0;
      case (step)
        0: if (req_valid) begin
          if (req_cmd == 4'hD || (!mem_cmd(req_cmd) && req_addr[63:32] != 0)) m_err = 1;
          else begin
            m_addr = req_addr; m_cmd = req_cmd; m_dual = (req_addr[63:32] != 0); step = 1;
          end
        end
        1: step = m_dual ? 2 : 3;
        2: step = 3;
        default: step = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    logic [63:0] ead;
    logic [7:0]  ecb;
    string       lt;
    if (!rst && !done) begin
      case (step)
        0: begin ead = '0; ecb = 8'hFF; lt = "R5"; end
        1: if (m_dual) begin ead = m_addr; ecb = {m_cmd, 4'hD}; lt = "R3"; end
           else begin ead = {32'h0, m_addr[31:0]}; ecb = {4'hF, m_cmd}; lt = "R2"; end
        2: begin ead = {32'h0, m_addr[63:32]}; ecb = {4'hF, m_cmd}; lt = "R4"; end
        default: begin ead = '0; ecb = 8'h00; lt = "R5"; end
      endcase
      chk({lt, " wide ad"}, w_ad, ead);
      chk({lt, " wide cbe"}, {56'h0, w_cbe}, {56'h0, ecb});
      chk({lt, " narrow ad"}, {32'h0, n_ad}, {32'h0, ead[31:0]});
      chk({lt, " narrow cbe"}, {60'h0, n_cbe}, {60'h0, ecb[3:0]});
      chk("R5 frame", {62'h0, w_frame, n_frame}, {62'h0, step == 0, step == 0});
      chk("R5 data_go", {62'h0, w_dgo, n_dgo}, {62'h0, step == 3, step == 3});
      chk("R4 addr_phase", {62'h0, w_aph, n_aph},
          {62'h0, step == 1 || step == 2, step == 1 || step == 2});
      chk("R7 ready", {62'h0, w_ready, n_ready}, {62'h0, step == 0, step == 0});
      chk("R6 err", {62'h0, w_err, n_err}, {62'h0, m_err, m_err});
      chk("R8 dec_valid", {62'h0, w_dv, n_dv}, {62'h0, e_dvw, e_dvn});
      if (e_dvw) begin
        chk("R8 wide dec_addr", w_daddr, e_daddr);
        chk("R8 wide dec_cmd", {60'h0, w_dcmd}, {60'h0, e_dcmd});
        chk("R8 wide dec_early", {63'h0, w_early}, {63'h0, e_early});
      end
      if (e_dvn) begin
        chk("R8 narrow dec_addr", n_daddr, e_daddr);
        chk("R8 narrow dec_cmd", {60'h0, n_dcmd}, {60'h0, e_dcmd});
        chk("R8 narrow dec_early", {63'h0, n_early}, 64'h0);
      end
    end
  end

  task automatic send(input logic [63:0] a, input logic [3:0] c);
    @(negedge clk);
    while (!w_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmd = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // R7: one-clock stray request while a sequence is running
  task automatic poke();
    req_valid = 1'b1; req_addr = 64'h5555_AAAA_1111_2222; req_cmd = 4'h2;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state, sampled while reset is still held
    chk("R1 frame", {62'h0, w_frame, n_frame}, 64'h3);
    chk("R1 ready", {62'h0, w_ready, n_ready}, 64'h3);
    chk("R1 err", {62'h0, w_err, n_err}, 64'h0);
    chk("R1 lanes", {w_ad | {32'h0, n_ad}}, 64'h0);
    chk("R1 cbe", {56'h0, w_cbe}, 64'hFF);
    chk("R1 dec_valid", {62'h0, w_dv, n_dv}, 64'h0);
    rst = 1'b0;
    send(64'h0000_0000_1234_5678, 4'h6);   // R2 single address
    send(64'h0000_0001_0000_0000, 4'h7);   // R3 exactly 4 GB
    send(64'h0000_0000_FFFF_FFFF, 4'hC);   // R2 just below 4 GB
    send(64'hDEAD_BEEF_CAFE_F00D, 4'hE);   // R3 R4 full pattern
    poke();
    send(64'h0000_0003_0000_0010, 4'h2);   // R6 non-memory high address
    send(64'h0000_0000_0000_0010, 4'h2);   // R6 non-memory low address runs
    send(64'h0000_0000_0000_0040, 4'hD);   // R6 dual code as command
    send(64'h8000_0000_0000_0004, 4'hF);   // R3 R4
    poke();
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a;
      logic [3:0]  c;
      a = (64'h0123_4567_89AB_CDEF * (i + 1)) ^ (64'h1 << (i * 3));
      if (i % 3 == 0) a[63:32] = '0;
      c = 4'(i * 5 + 6);
      send(a, c);
      if (i % 4 == 1) poke();
    end
    repeat (6) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule